// File: doc/BRIEF.md
# Dual-Channel Guarded Clock Prescaler

This block holds one 8-bit control word that configures two independent clock prescalers, one for each controller-area-network channel. Each channel has a 3-bit ratio code. The code selects a power-of-two division of the input clock, from 1 to 16. Each channel also has a sleep flag that puts that channel's CPU-side interface to sleep. For each channel the block produces a one-cycle clock enable at the selected rate, and it reports the sleep flag on a separate output. The whole word can be read back at any time.

Writes are guarded in two layers:

- **Global guard.** A write has any effect only while the external protect-enable input is high.
- **Per-channel guard.** A channel's ratio code changes only while that channel reports initialization mode. A channel's sleep flag can be raised only while that channel's sleep-permit input is already high.

A write that carries a reserved ratio code leaves that channel's ratio as it was. When a ratio changes, the prescaler restarts its count from zero, so no shortened interval ever appears between enables.

Top module: `dual_clk_prescaler`

## Requirements
- R1: After reset, `cfg_rd` reads 0x00, both `if_sleep` bits are 0, and both `tick` bits are high every cycle.
- R2: The control word layout is: bits [2:0] hold the channel 0 ratio code, bit 3 the channel 0 sleep flag, bits [6:4] the channel 1 ratio code, and bit 7 the channel 1 sleep flag. An accepted write is visible on `cfg_rd` in the cycle after the write edge.
- R3: Ratio codes 0, 1, 2, 3 and 4 give one `tick` pulse, one cycle wide, every 1, 2, 4, 8 and 16 clocks.
- R4: A write while `prot_en` is 0 changes no bit of the control word.
- R5: A channel's ratio code changes only if that channel's `ch_init` bit is 1 at the write edge; otherwise the old code is kept.
- R6: A write that carries ratio code 5, 6 or 7 for a channel leaves that channel's ratio code unchanged.
- R7: A write can raise a channel's sleep flag from 0 to 1 only if that channel's `sleep_ok` bit is 1. A flag that is already 1 may be kept at 1, and clearing it to 0 is always accepted.
- R8: While a channel's sleep flag is 1, that channel's `tick` output is 0.
- R9: After a ratio change written at clock edge E, the first `tick` of that channel appears N+1 cycles after E, where N is the new ratio. Ticks then repeat every N cycles.
- R10: The two channels are independent: one channel's settings never alter the other channel's field or its tick rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word to write |
| prot_en | input | 1 | Global write permission |
| ch_init | input | 2 | Per channel: 1 when the channel is in initialization mode |
| sleep_ok | input | 2 | Per channel: 1 when sleep entry is permitted |
| cfg_rd | output | 8 | Readback of the control word |
| tick | output | 2 | Per-channel divided clock enable |
| if_sleep | output | 2 | Per-channel interface sleep flag |

## Verification
A control field that is held or updated wrongly shows up on `cfg_rd` in the cycle right after the write edge. The table of writes therefore catches every mistake in the guard logic one cycle after it happens. A prescaler counter that is wrong or that fails to restart shows up more slowly: as a wrong latency to the first `tick`, at most 17 cycles after the change, or as a wrong pulse count over a 64-cycle window. A broken sleep mask shows up as any `tick` pulse while `if_sleep` is high.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int NUM_CH   = 2;
    localparam int CODE_W   = 3;
    localparam int FIELD_W  = CODE_W + 1;
    localparam int REG_W    = NUM_CH * FIELD_W;
    localparam int MAX_CODE = 4;
    localparam int CNT_W    = MAX_CODE;

    typedef struct packed {
        logic              sleep;
        logic [CODE_W-1:0] code;
    } ch_field_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return c <= CODE_W'(MAX_CODE);
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        return (one << c) - one;
    endfunction
endpackage

// File: rtl/ch_cfg_field.sv
module ch_cfg_field
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      prot_en,
    input  logic      init_mode,
    input  logic      sleep_ok,
    input  ch_field_t wfield,
    output ch_field_t field
);
    always_ff @(posedge clk) begin
        if (rst) begin
            field <= '0;
        end else if (wr && prot_en) begin
            if (init_mode && code_ok(wfield.code))
                field.code <= wfield.code;
            field.sleep <= wfield.sleep & (sleep_ok | field.sleep);
        end
    end

    // R4
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && prot_en) |=> $stable(field));
    // R5
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !init_mode |=> $stable(field.code));
    // R6
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        field.code <= CODE_W'(MAX_CODE));
    // R7
    sleep_permit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(field.sleep) |-> $past(sleep_ok));
endmodule

// File: rtl/pow2_divider.sv
module pow2_divider
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              tick_raw
);
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt;
    logic              changed;
    logic              at_end;

    assign changed  = code != code_q;
    assign at_end   = cnt == last_count(code);
    assign tick_raw = at_end && !changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            cnt    <= '0;
        end else begin
            code_q <= code;
            if (changed || at_end)
                cnt <= '0;
            else
                cnt <= cnt + CNT_W'(1);
        end
    end

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        changed |=> cnt == '0);
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_raw && code != '0) |=> !tick_raw);
endmodule

// File: rtl/dual_clk_prescaler.sv
module dual_clk_prescaler
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             prot_en,
    input  logic [NUM_CH-1:0] ch_init,
    input  logic [NUM_CH-1:0] sleep_ok,
    output logic [REG_W-1:0] cfg_rd,
    output logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-1:0] if_sleep
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_field_t wf;
        ch_field_t cur;
        logic      raw;

        assign wf = ch_field_t'(cfg_wdata[i*FIELD_W +: FIELD_W]);

        ch_cfg_field u_cfg (
            .clk       (clk),
            .rst       (rst),
            .wr        (cfg_wr),
            .prot_en   (prot_en),
            .init_mode (ch_init[i]),
            .sleep_ok  (sleep_ok[i]),
            .wfield    (wf),
            .field     (cur)
        );

        pow2_divider u_div (
            .clk      (clk),
            .rst      (rst),
            .code     (cur.code),
            .tick_raw (raw)
        );

        assign cfg_rd[i*FIELD_W +: FIELD_W] = cur;
        assign if_sleep[i] = cur.sleep;
        assign tick[i]     = raw & ~cur.sleep;

        // R8
        sleep_mask_chk: assert property (@(posedge clk) disable iff (rst)
            $past(if_sleep[i]) && if_sleep[i] |-> !tick[i]);
    end
endmodule

// File: tb/test_dual_clk_prescaler.sv
`timescale 1ns/1ps
module test_dual_clk_prescaler;
    logic       clk = 0;
    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic       prot_en;
    logic [1:0] ch_init;
    logic [1:0] sleep_ok;
    logic [7:0] cfg_rd;
    logic [1:0] tick;
    logic [1:0] if_sleep;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_clk_prescaler i_dual_clk_prescaler (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .prot_en(prot_en), .ch_init(ch_init), .sleep_ok(sleep_ok),
        .cfg_rd(cfg_rd), .tick(tick), .if_sleep(if_sleep)
    );

    // {prot, init[1:0], sleep_ok[1:0], wdata, expected readback}
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 2'b11, 2'b11, 8'h21, 8'h21},  // R2 accepted write
        {1'b0, 2'b11, 2'b11, 8'h44, 8'h21},  // R4 protect off
        {1'b1, 2'b01, 2'b11, 8'h33, 8'h23},  // R5 ch1 not in init
        {1'b1, 2'b11, 2'b11, 8'h76, 8'h23},  // R6 reserved codes
        {1'b1, 2'b11, 2'b10, 8'h88, 8'h80},  // R7 ch0 sleep refused
        {1'b1, 2'b00, 2'b00, 8'h88, 8'h80},  // R7 held sleep kept
        {1'b1, 2'b11, 2'b01, 8'h4C, 8'h4C},  // R7 set ch0, clear ch1
        {1'b1, 2'b11, 2'b00, 8'h04, 8'h04}   // R10 independent fields
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [1:0] ini, input logic [1:0] ok,
                      input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1; prot_en = p; ch_init = ini; sleep_ok = ok; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic ratio_test(input int code);
        int n, lat, cnt0, cnt1;
        n = 1 << code;
        wr(1, 2'b11, 2'b00, 8'(code));
        lat = 1;
        while (!tick[0] && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R9 first tick latency", lat, n + 1);
        cnt0 = 0; cnt1 = 0;
        for (int k = 0; k < 64; k++) begin
            cnt0 += int'(tick[0]);
            cnt1 += int'(tick[1]);
            @(negedge clk);
        end
        check("R3 tick count in 64 cycles", cnt0, 64 / n);
        check("R10 other channel unaffected", cnt1, 64);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        rst = 1; cfg_wr = 0; cfg_wdata = 0; prot_en = 0; ch_init = 0; sleep_ok = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 readback", cfg_rd, 8'h00);
        check("R1 sleep flags", if_sleep, 0);
        c = 0;
        for (int k = 0; k < 8; k++) begin
            c += int'(tick == 2'b11);
            @(negedge clk);
        end
        check("R1 undivided ticks", c, 8);

        foreach (VEC[i]) begin
            wr(VEC[i][20], VEC[i][19:18], VEC[i][17:16], VEC[i][15:8]);
            check($sformatf("R2 table vector %0d", i), cfg_rd, VEC[i][7:0]);
        end

        for (int code = 1; code <= 4; code++) ratio_test(code);
        ratio_test(0);

        // R8 sleeping channel is silent, R10 other keeps ticking
        wr(1, 2'b11, 2'b01, 8'h08);
        check("R8 sleep flag", if_sleep, 2'b01);
        c = 0;
        for (int k = 0; k < 32; k++) begin
            c += int'(tick[0]);
            check("R10 ch1 ticks during ch0 sleep", tick[1], 1);
            @(negedge clk);
        end
        check("R8 ticks while asleep", c, 0);

        // R6 reserved code with init set: ratio stays at 1, ticks continue
        wr(1, 2'b11, 2'b00, 8'h05);
        check("R6 reserved code kept", cfg_rd, 8'h00);
        check("R6 tick unchanged", tick[0], 1);

        // R4 protect off: sleep request ignored, ticks continue
        wr(0, 2'b11, 2'b11, 8'h88);
        check("R4 no sleep", if_sleep, 0);
        check("R4 ticks", tick, 2'b11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule